// File: doc/BRIEF.md
# BCD Time-of-Day Calendar Register Bank

This block keeps wall-clock time and date as packed BCD bytes: seconds, minutes, hours, weekday, day of month, month and year. A one-cycle pulse on `sec_tick` advances the time by one second. Software reaches the time through a synchronous register port with a 4-bit index. Writes take effect at the clock edge, and read data is registered, so it appears one cycle after the index.

The running counters and the bytes that software sees are kept apart. A small state machine picks which copy the read port shows and when writes are accepted. It has three states:
- `ST_LIVE`: reads show the running counters.
- `ST_FROZEN`: reads show a snapshot taken on entry, while the counters keep running.
- `ST_STAGING`: the counters are held, and software edits a staging copy.

Every transition is caused by a write to the control register, and the next state depends only on the two control bits written:
- "hold" (bit 7) set leads to `ST_STAGING` from any state. Entering it loads the staging copy from the counters.
- "freeze" (bit 6) alone leads to `ST_FROZEN`. Entering it loads the snapshot.
- Both bits clear lead to `ST_LIVE`.
- Leaving `ST_STAGING` commits the staging copy to the counters in one edge. Going from `ST_STAGING` to `ST_FROZEN` snapshots the committed values.
- Writing the state already held keeps that state and loads nothing.

Top module: `tod_regbank`

## Requirements
- R1: After reset the bytes read: control 0x00, seconds 0x00, minutes 0x00, hours 0x00, weekday 0x01, day 0x01, month 0x01, year 0x00.
- R2: The register index map is 0 control, 1 seconds, 2 minutes, 3 hours, 4 weekday, 5 day, 6 month, 7 year. Indices 8 to 15 read 0x00, and writes to them have no effect.
- R3: Each `sec_tick` advances seconds 00..59. Seconds wrapping carries into minutes (00..59), and minutes wrapping carries into hours (00..23), all in BCD.
- R4: Hours wrapping advances the weekday (low 3 bits, 1..7 then 1). Month runs 01..12 and year 00..99, in BCD, each wrapping and carrying upward.
- R5: Day of month wraps to 01 after its month length:
  - 30 days for months 04, 06, 09 and 11;
  - 29 days for month 02 when the year value is a multiple of 4, otherwise 28;
  - 31 days for every other month.
- R6: Writing control with bit 7 set holds the counters and ignores ticks. Reads show the staging copy, and writes to indices 1..7 update it. Clearing bit 7 loads all staged bytes into the counters at once.
- R7: Writing control with bit 6 set (bit 7 clear) freezes the read values while the counters keep counting. Clearing bit 6 makes reads show the live count again.
- R8: Writes to indices 1..7 outside the hold state have no effect.
- R9: While seconds bit 7 (stop) is set, ticks are ignored and the time does not change.
- R10: With weekday bit 6 (frequency test) set, seconds read bit 0 shows a square wave that flips on every `hf_tick` strobe (512 Hz from a 1024 Hz strobe).
- R11: With weekday bit 5 (century enable) set, weekday bit 4 toggles when the year wraps from 99 to 00.
- R12: If control bit 7 and bit 6 are written together, hold wins. Clearing only bit 7 afterwards commits the staged values and freezes reads on the committed time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| hf_tick | input | 1 | One-cycle pulse at 1024 Hz for the frequency test |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (4) | Register index |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data, valid one cycle after the index |

## Verification
The bench builds the block with the default 4-bit index, so all sixteen indices, including the eight unused ones, are swept.

A complete one-minute sweep of seconds covers every BCD digit step and the carry into minutes. The write-hold path is then used to place the clock at 23:59:59 on the last day of each of the twelve months, in four years (two leap and two common, one being 99). This brings every month-end, both February lengths, the December year carry and the century wrap within a few thousand cycles.

// File: rtl/tod_pkg.sv
package tod_pkg;

    localparam int BYTE_W = 8;

    // Register indices; software decodes these.
    localparam int IDX_CTRL = 0;
    localparam int IDX_SEC  = 1;
    localparam int IDX_MIN  = 2;
    localparam int IDX_HOUR = 3;
    localparam int IDX_WDAY = 4;
    localparam int IDX_DAY  = 5;
    localparam int IDX_MON  = 6;
    localparam int IDX_YEAR = 7;
    localparam int IDX_LAST = 7;

    typedef struct packed {
        logic [BYTE_W-1:0] year;
        logic [BYTE_W-1:0] mon;
        logic [BYTE_W-1:0] day;
        logic [BYTE_W-1:0] wday;
        logic [BYTE_W-1:0] hour;
        logic [BYTE_W-1:0] min;
        logic [BYTE_W-1:0] sec;
    } tod_t;

    typedef enum logic [1:0] {
        ST_LIVE    = 2'd0,
        ST_FROZEN  = 2'd1,
        ST_STAGING = 2'd2
    } view_e;

    localparam tod_t TOD_RESET = '{year: 8'h00, mon: 8'h01, day: 8'h01,
                                   wday: 8'h01, hour: 8'h00, min: 8'h00,
                                   sec: 8'h00};

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
    endfunction

    // 10*t + o is a multiple of 4 exactly when 2*t[0] + o[1:0] is.
    function automatic logic [7:0] month_len(input logic [7:0] mon,
                                             input logic [7:0] year);
        logic [1:0] r;
        r = {year[4], 1'b0} + year[1:0];
        unique case (mon)
            8'h02:                      return (r == 2'd0) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    function automatic tod_t tod_advance(input tod_t t);
        tod_t       n;
        logic       c;
        logic [7:0] tmp;
        n = t;
        c = 1'b0;
        if (t.sec[6:0] == 7'h59) begin
            n.sec = {t.sec[7], 7'h00};
            c = 1'b1;
        end else begin
            tmp   = bcd_inc({1'b0, t.sec[6:0]});
            n.sec = {t.sec[7], tmp[6:0]};
        end
        if (c) begin
            if (t.min == 8'h59) n.min = 8'h00;
            else begin n.min = bcd_inc(t.min); c = 1'b0; end
        end
        if (c) begin
            if (t.hour == 8'h23) n.hour = 8'h00;
            else begin n.hour = bcd_inc(t.hour); c = 1'b0; end
        end
        if (c) begin
            n.wday[2:0] = (t.wday[2:0] == 3'd7) ? 3'd1 : t.wday[2:0] + 3'd1;
            if (t.day == month_len(t.mon, t.year)) n.day = 8'h01;
            else begin n.day = bcd_inc(t.day); c = 1'b0; end
        end
        if (c) begin
            if (t.mon == 8'h12) n.mon = 8'h01;
            else begin n.mon = bcd_inc(t.mon); c = 1'b0; end
        end
        if (c) begin
            if (t.year == 8'h99) begin
                n.year = 8'h00;
                if (t.wday[5]) n.wday[4] = ~t.wday[4];
            end else begin
                n.year = bcd_inc(t.year);
            end
        end
        return n;
    endfunction

endpackage

// File: rtl/tod_view_fsm.sv
module tod_view_fsm
    import tod_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_we,
    input  logic [1:0] ctrl_bits_in,   // {hold, freeze}
    output view_e      state_o,
    output logic [1:0] ctrl_bits_o,
    output logic       commit_o,
    output logic       snap_load_o,
    output logic       stage_load_o
);
    view_e      state_q, state_d;
    logic [1:0] bits_q;

    always_comb begin
        state_d = state_q;
        if (ctrl_we) begin
            unique case (ctrl_bits_in)
                2'b10, 2'b11: state_d = ST_STAGING;
                2'b01:        state_d = ST_FROZEN;
                default:      state_d = ST_LIVE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LIVE;
            bits_q  <= 2'b00;
        end else begin
            state_q <= state_d;
            if (ctrl_we) bits_q <= ctrl_bits_in;
        end
    end

    always_comb begin
        commit_o     = 1'b0;
        snap_load_o  = 1'b0;
        stage_load_o = 1'b0;
        unique case (state_q)
            ST_LIVE: begin
                snap_load_o  = (state_d == ST_FROZEN);
                stage_load_o = (state_d == ST_STAGING);
            end
            ST_FROZEN: begin
                stage_load_o = (state_d == ST_STAGING);
            end
            ST_STAGING: begin
                commit_o    = (state_d != ST_STAGING);
                snap_load_o = (state_d == ST_FROZEN);
            end
            default: ;
        endcase
    end

    assign state_o     = state_q;
    assign ctrl_bits_o = bits_q;

    // R12
    hold_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && ctrl_bits_in == 2'b11) |=> (state_q == ST_STAGING));

    // R6
    commit_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> (state_q != ST_STAGING));

endmodule

// File: rtl/tod_counter.sv
module tod_counter
    import tod_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic hold_i,
    input  logic load_i,
    input  tod_t load_val_i,
    output tod_t cnt_o
);
    tod_t cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                            cnt_q <= TOD_RESET;
        else if (load_i)                       cnt_q <= load_val_i;
        else if (tick_i && !hold_i && !cnt_q.sec[7]) cnt_q <= tod_advance(cnt_q);
    end

    assign cnt_o = cnt_q;

    // R6
    hold_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && !load_i) |=> $stable(cnt_q));

    // R9
    stop_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q.sec[7] && !load_i) |=> $stable(cnt_q));

    // R3
    min_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q.sec[6:0] != 7'h59) |=> $stable(cnt_q.min));

endmodule

// File: rtl/tod_shadow.sv
module tod_shadow
    import tod_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  tod_t       cnt_i,
    input  logic       frozen_i,
    input  logic       snap_load_i,
    input  logic       commit_i,
    input  logic       stage_load_i,
    input  logic       stage_we_i,
    input  logic [2:0] stage_idx_i,
    input  logic [7:0] wdata_i,
    output tod_t       snap_o,
    output tod_t       stage_o
);
    tod_t snap_q, stage_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q  <= TOD_RESET;
            stage_q <= TOD_RESET;
        end else begin
            if (snap_load_i) snap_q <= commit_i ? stage_q : cnt_i;
            if (stage_load_i) begin
                stage_q <= cnt_i;
            end else if (stage_we_i) begin
                unique case (int'(stage_idx_i))
                    IDX_SEC:  stage_q.sec  <= wdata_i;
                    IDX_MIN:  stage_q.min  <= {1'b0, wdata_i[6:0]};
                    IDX_HOUR: stage_q.hour <= {2'b0, wdata_i[5:0]};
                    IDX_WDAY: stage_q.wday <= {1'b0, wdata_i[6:4], 1'b0, wdata_i[2:0]};
                    IDX_DAY:  stage_q.day  <= {2'b0, wdata_i[5:0]};
                    IDX_MON:  stage_q.mon  <= {3'b0, wdata_i[4:0]};
                    IDX_YEAR: stage_q.year <= wdata_i;
                    default: ;
                endcase
            end
        end
    end

    assign snap_o  = snap_q;
    assign stage_o = stage_q;

    // R7
    snap_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen_i && !snap_load_i) |=> $stable(snap_q));

endmodule

// File: rtl/tod_regbank.sv
module tod_regbank
    import tod_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              hf_tick,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata
);
    localparam int N_REG = 1 << ADDR_W;

    view_e      state;
    logic [1:0] ctrl_bits;
    logic       commit, snap_load, stage_load, ctrl_we, stage_we, ft_phase;
    tod_t       cnt, snap, stage, view;
    logic [7:0] rd_d, rdata_q;
    int         idx;

    assign idx      = int'(bus_addr);
    assign ctrl_we  = bus_we && (idx == IDX_CTRL);
    assign stage_we = bus_we && (state == ST_STAGING) &&
                      (idx >= IDX_SEC) && (idx <= IDX_LAST) && (idx < N_REG);

    tod_view_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we),
        .ctrl_bits_in(bus_wdata[7:6]), .state_o(state),
        .ctrl_bits_o(ctrl_bits), .commit_o(commit),
        .snap_load_o(snap_load), .stage_load_o(stage_load)
    );

    tod_counter u_cnt (
        .clk(clk), .rst_n(rst_n), .tick_i(sec_tick),
        .hold_i(state == ST_STAGING), .load_i(commit),
        .load_val_i(stage), .cnt_o(cnt)
    );

    tod_shadow u_shd (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt),
        .frozen_i(state == ST_FROZEN), .snap_load_i(snap_load),
        .commit_i(commit), .stage_load_i(stage_load),
        .stage_we_i(stage_we), .stage_idx_i(bus_addr[2:0]),
        .wdata_i(bus_wdata), .snap_o(snap), .stage_o(stage)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)       ft_phase <= 1'b0;
        else if (hf_tick) ft_phase <= ~ft_phase;
    end

    always_comb begin
        unique case (state)
            ST_FROZEN:  view = snap;
            ST_STAGING: view = stage;
            default:    view = cnt;
        endcase
        unique case (idx)
            IDX_CTRL: rd_d = {ctrl_bits, 6'b0};
            IDX_SEC:  rd_d = {view.sec[7:1], view.wday[6] ? ft_phase : view.sec[0]};
            IDX_MIN:  rd_d = view.min;
            IDX_HOUR: rd_d = view.hour;
            IDX_WDAY: rd_d = view.wday;
            IDX_DAY:  rd_d = view.day;
            IDX_MON:  rd_d = view.mon;
            IDX_YEAR: rd_d = view.year;
            default:  rd_d = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= 8'h00;
        else        rdata_q <= rd_d;
    end

    assign bus_rdata = rdata_q;

    // R2
    hi_idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx > IDX_LAST) |=> (bus_rdata == 8'h00));

endmodule

// File: tb/sim_tod_regbank.sv
module sim_tod_regbank;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0, hf_tick = 1'b0, bus_we = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    int checks = 0, fails = 0, hf_count = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    tod_regbank #(.ADDR_W(4)) u0 (.*);

    function automatic logic [7:0] to_bcd(input int v);
        return 8'((v / 10) * 16 + (v % 10));
    endfunction

    function automatic int mlen(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk); bus_we = 1'b1; bus_addr = 4'(a); bus_wdata = d;
        @(negedge clk); bus_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        @(negedge clk); bus_addr = 4'(a);
        @(negedge clk); d = bus_rdata;
    endtask

    task automatic tick();
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
    endtask

    task automatic hf();
        @(negedge clk); hf_tick = 1'b1;
        @(negedge clk); hf_tick = 1'b0;
        hf_count++;
    endtask

    task automatic set_time(input logic [7:0] s, mi, h, w, d, mo, y);
        wr(0, 8'h80);
        wr(1, s); wr(2, mi); wr(3, h); wr(4, w); wr(5, d); wr(6, mo); wr(7, y);
        wr(0, 8'h00);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        logic [7:0] rst_exp [8] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values; R2 high indices read zero
        for (int i = 0; i < 8; i++) begin rd(i, v); check("R1 reset", v, rst_exp[i]); end
        for (int i = 8; i < 16; i++) begin rd(i, v); check("R2 high index", v, 8'h00); end

        // R3 full minute sweep
        for (int i = 1; i <= 60; i++) begin
            tick(); rd(1, v); check("R3 seconds", v, to_bcd(i % 60));
        end
        rd(2, v); check("R3 minute carry", v, 8'h01);

        // R3 hour rollover to weekday (R4)
        set_time(8'h59, 8'h59, 8'h22, 8'h03, 8'h10, 8'h05, 8'h30);
        tick(); rd(3, v); check("R3 hour carry", v, 8'h23); rd(2, v); check("R3 min wrap", v, 8'h00);
        set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h10, 8'h05, 8'h30);
        tick(); rd(3, v); check("R3 hour wrap", v, 8'h00);
        rd(4, v); check("R4 weekday wrap", v, 8'h01); rd(5, v); check("R5 mid-month", v, 8'h11);

        // R5 / R4 month-end sweep over four years
        foreach (rst_exp[k]) ; // no-op keeps loop style uniform
        for (int yi = 0; yi < 4; yi++) begin
            int yr;
            yr = (yi == 0) ? 23 : (yi == 1) ? 24 : (yi == 2) ? 0 : 99;
            for (int m = 1; m <= 12; m++) begin
                int dl;
                dl = mlen(m, yr);
                set_time(8'h59, 8'h59, 8'h23, 8'h02, to_bcd(dl - 1), to_bcd(m), to_bcd(yr));
                tick(); rd(5, v); check("R5 last day reached", v, to_bcd(dl));
                set_time(8'h59, 8'h59, 8'h23, 8'h02, to_bcd(dl), to_bcd(m), to_bcd(yr));
                tick();
                rd(5, v); check("R5 day wrap", v, 8'h01);
                rd(6, v); check("R4 month", v, to_bcd(m == 12 ? 1 : m + 1));
                rd(7, v); check("R4 year", v, to_bcd(m == 12 ? (yr + 1) % 100 : yr));
            end
        end

        // R11 century toggle
        set_time(8'h59, 8'h59, 8'h23, 8'h27, 8'h31, 8'h12, 8'h99);
        tick(); rd(4, v); check("R11 century bit", v, 8'h31); rd(7, v); check("R11 year", v, 8'h00);
        set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
        tick(); rd(4, v); check("R11 disabled", v, 8'h01);

        // R8 writes outside hold ignored; R2 high index writes ignored
        set_time(8'h10, 8'h20, 8'h05, 8'h01, 8'h01, 8'h01, 8'h00);
        wr(1, 8'h44); rd(1, v); check("R8 ignored write", v, 8'h10);
        wr(0, 8'h80); wr(9, 8'hFF); rd(9, v); check("R2 high write", v, 8'h00); wr(0, 8'h00);

        // R6 hold: ticks ignored, staged values commit at once
        wr(0, 8'h80); rd(0, v); check("R6 control", v, 8'h80);
        tick(); tick(); rd(1, v); check("R6 staged view", v, 8'h10);
        wr(2, 8'h33); rd(2, v); check("R6 staged write", v, 8'h33);
        wr(0, 8'h00); rd(2, v); check("R6 commit min", v, 8'h33); rd(1, v); check("R6 ticks held", v, 8'h10);

        // R7 freeze
        wr(0, 8'h40); tick(); tick(); tick();
        rd(1, v); check("R7 frozen", v, 8'h10);
        wr(0, 8'h00); rd(1, v); check("R7 live again", v, 8'h13);

        // R12 both bits
        wr(0, 8'hC0); rd(0, v); check("R12 control", v, 8'hC0);
        wr(1, 8'h50); tick(); rd(1, v); check("R12 staging", v, 8'h50);
        wr(0, 8'h40); tick(); rd(1, v); check("R12 frozen committed", v, 8'h50);
        wr(0, 8'h00); rd(1, v); check("R12 counters ran", v, 8'h51);

        // R9 stop bit
        set_time(8'h85, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
        tick(); tick(); tick(); rd(1, v); check("R9 stopped", v, 8'h85);
        set_time(8'h05, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
        tick(); rd(1, v); check("R9 restarted", v, 8'h06);

        // R10 frequency test
        set_time(8'h20, 8'h00, 8'h00, 8'h41, 8'h01, 8'h01, 8'h00);
        for (int i = 0; i < 5; i++) begin
            hf(); rd(1, v); check("R10 ft toggle", v, {7'b0010000, 1'(hf_count % 2)});
        end
        set_time(8'h20, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
        hf(); rd(1, v); check("R10 ft off", v, 8'h20);

        finish_run();
    end
endmodule